// File: doc/BRIEF.md
# Disk Register Command Sequencer

This block sits between a storage controller and the register file of a parallel ATA disk. It performs two jobs. The first is a software reset of the drive. The second is the issue of a sector read/write or DMA command. For each job it runs a fixed series of register accesses with the required waits, and then polls the drive status. It returns a result code to the controller, and it also returns the drive's error register when the drive reports a fault.

The controller presents one request on a valid/ready pair. A command request carries a command code, a sector count, a 28-bit LBA and a drive select bit. The block places the LBA bits on the drive registers, including the top nibble in the device register, and then writes the command code. After a settling window it polls status until the ready value appears, an error is flagged or the poll budget runs out.

A caller that holds a cylinder/head/sector address converts it first with LBA = (cylinder × heads + head) × sectors_per_track + sector − 1. The block itself only accepts LBA form.

Top module: `disk_cmd_seq`

## Requirements
- R1: After reset, `req_ready` is 1, `done` is 0 and neither `reg_wr` nor `reg_rd` is asserted.
- R2: A command request (`req_op`=0) produces exactly six writes, one per cycle, in this order: count (address 2h), LBA[7:0] (3h), LBA[15:8] (4h), LBA[23:16] (5h), device (6h), command code (7h).
- R3: The device byte is {1, 1 (LBA mode), 1, drive select, LBA[27:24]}, that is E0h | drive<<4 | LBA[27:24].
- R4: After the command write, the block spends exactly `SETTLE_CYC` cycles reading the alternate status (Eh) and the error register (1h), and discards those values. The first status read (address 7h) comes `SETTLE_CYC`+1 cycles after the command write.
- R5: A command completes with result 0 when a status read returns exactly 58h. `done` rises in the cycle after that read.
- R6: A reset request (`req_op`=1) writes 04h (soft-reset bit) to the control address Eh, then idles the bus for `RST_WAIT_CYC` cycles, then polls status until it reads exactly 80h, which gives result 0.
- R7: A status read with bit 0 (error) set and bit 7 (busy) clear stops polling. The next cycle reads the error register (1h). The operation then ends with result 1, and `err_value` holds the value read. The error bit is ignored while busy is set.
- R8: If `POLL_LIMIT` status reads pass with neither a match nor an error, the operation ends with result 2, and no further status read is made.
- R9: `done` is a single-cycle pulse. `req_ready` is high only while idle, so a request is taken only when `req_ready` is 1.
- R10: `reg_wr` and `reg_rd` are never asserted together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_op | input | 1 | 0 = command, 1 = drive soft reset |
| req_cmd | input | 8 | Command code |
| req_count | input | 8 | Sector count |
| req_lba | input | 28 | Logical block address |
| req_drive | input | 1 | Drive select |
| req_ready | output | 1 | Idle and able to take a request |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 0 ok, 1 drive error, 2 timeout |
| err_value | output | 8 | Error register value on result 1, else 0 |
| reg_addr | output | 4 | Drive register address |
| reg_wdata | output | 8 | Write data to drive |
| reg_wr | output | 1 | Write strobe, one cycle per access |
| reg_rd | output | 1 | Read strobe, one cycle per access |
| reg_rdata | input | 8 | Read data from drive, valid in the cycle of `reg_rd` |

## Verification
The assertions assume that the drive returns read data in the same cycle as the read strobe, and that `req_valid` is raised only while `req_ready` is high. They also assume that `SETTLE_CYC`, `RST_WAIT_CYC` and `POLL_LIMIT` are at least 1. The bench's drive model answers combinationally from the address. It presents `req_valid` for exactly one cycle, at a moment when `req_ready` is high. It picks its status sequences so that the pre-ready value never equals the target value, which lets the expected number of polls be computed in closed form.

// File: rtl/disk_seq_pkg.sv
`timescale 1ns/1ps
// Shared types and constants for the disk command sequencer.
// Assumes a 4-bit drive register address: 1h..7h command block, Eh control block.
package disk_seq_pkg;
    typedef enum logic [3:0] {
        ST_IDLE, ST_RST_SET, ST_RST_WAIT,
        ST_W_CNT, ST_W_LO, ST_W_MID, ST_W_HI, ST_W_DEV, ST_W_CMD,
        ST_SETTLE, ST_POLL, ST_RD_ERR, ST_DONE
    } seq_state_e;

    typedef enum logic [1:0] {
        RES_OK = 2'd0, RES_DEV_ERR = 2'd1, RES_TIMEOUT = 2'd2
    } seq_result_e;

    localparam logic [3:0] TF_ERROR    = 4'h1;
    localparam logic [3:0] TF_COUNT    = 4'h2;
    localparam logic [3:0] TF_LBA_LO   = 4'h3;
    localparam logic [3:0] TF_LBA_MID  = 4'h4;
    localparam logic [3:0] TF_LBA_HI   = 4'h5;
    localparam logic [3:0] TF_DEVICE   = 4'h6;
    localparam logic [3:0] TF_CMD_STAT = 4'h7;
    localparam logic [3:0] TF_CTRL_ALT = 4'hE;

    localparam logic [7:0] CTRL_SRST       = 8'h04;
    localparam logic [7:0] STAT_RESET_OK   = 8'h80;
    localparam logic [7:0] STAT_XFER_READY = 8'h58;
endpackage

// File: rtl/seq_downcount.sv
`timescale 1ns/1ps
// Loadable down-counter used for wait windows and the poll budget.
// Assumes load has priority over dec, and that the count stops at zero.
module seq_downcount #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    input  logic             dec,
    output logic [WIDTH-1:0] cnt,
    output logic             zero
);
    // Count register: load, or step down toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n)               cnt <= '0;
        else if (load)            cnt <= load_val;
        else if (dec && cnt != 0) cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/tf_bus_drive.sv
`timescale 1ns/1ps
// Decodes the sequencer state into one drive-register access per cycle.
// Assumes the state machine stays one cycle in each write state.
module tf_bus_drive
    import disk_seq_pkg::*;
(
    input  seq_state_e  state,
    input  logic [7:0]  cmd,
    input  logic [7:0]  count,
    input  logic [27:0] lba,
    input  logic        drive,
    input  logic        phase,
    output logic [3:0]  addr,
    output logic [7:0]  wdata,
    output logic        wr,
    output logic        rd
);
    // Address, data and strobe selection for the current state.
    always_comb begin
        addr  = TF_CMD_STAT;
        wdata = 8'h00;
        wr    = 1'b0;
        rd    = 1'b0;
        case (state)
            ST_RST_SET: begin addr = TF_CTRL_ALT; wdata = CTRL_SRST; wr = 1'b1; end
            ST_W_CNT:   begin addr = TF_COUNT;    wdata = count;       wr = 1'b1; end
            ST_W_LO:    begin addr = TF_LBA_LO;   wdata = lba[7:0];    wr = 1'b1; end
            ST_W_MID:   begin addr = TF_LBA_MID;  wdata = lba[15:8];   wr = 1'b1; end
            ST_W_HI:    begin addr = TF_LBA_HI;   wdata = lba[23:16];  wr = 1'b1; end
            ST_W_DEV:   begin
                addr  = TF_DEVICE;
                wdata = {1'b1, 1'b1, 1'b1, drive, lba[27:24]};
                wr    = 1'b1;
            end
            ST_W_CMD:   begin addr = TF_CMD_STAT; wdata = cmd; wr = 1'b1; end
            ST_SETTLE:  begin addr = phase ? TF_CTRL_ALT : TF_ERROR; rd = 1'b1; end
            ST_POLL:    begin addr = TF_CMD_STAT; rd = 1'b1; end
            ST_RD_ERR:  begin addr = TF_ERROR;    rd = 1'b1; end
            default:    ;
        endcase
    end
endmodule

// File: rtl/disk_cmd_seq.sv
`timescale 1ns/1ps
// Disk register command sequencer: a soft reset, or a command issued
// through the drive registers, each followed by status polling.
// Assumes read data is valid in the same cycle as reg_rd.
module disk_cmd_seq
    import disk_seq_pkg::*;
#(
    parameter int RST_WAIT_CYC = 400000,
    parameter int SETTLE_CYC   = 80,
    parameter int POLL_LIMIT   = 100000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_op,
    input  logic [7:0]  req_cmd,
    input  logic [7:0]  req_count,
    input  logic [27:0] req_lba,
    input  logic        req_drive,
    output logic        req_ready,
    output logic        done,
    output logic [1:0]  result,
    output logic [7:0]  err_value,
    output logic [3:0]  reg_addr,
    output logic [7:0]  reg_wdata,
    output logic        reg_wr,
    output logic        reg_rd,
    input  logic [7:0]  reg_rdata
);
    localparam int MAX_AB = (RST_WAIT_CYC > SETTLE_CYC) ? RST_WAIT_CYC : SETTLE_CYC;
    localparam int MAX_C  = (MAX_AB > POLL_LIMIT) ? MAX_AB : POLL_LIMIT;
    localparam int CW     = $clog2(MAX_C + 1);

    seq_state_e  state, nxt;
    logic        is_reset_q, drive_q;
    logic [7:0]  cmd_q, count_q, err_q;
    logic [27:0] lba_q;
    seq_result_e res_q;

    logic          wait_load, wait_zero, poll_load, poll_zero;
    logic [CW-1:0] wait_val, wait_cnt, poll_cnt;
    logic [7:0]    target;
    logic          stat_err, stat_hit;

    assign target   = is_reset_q ? STAT_RESET_OK : STAT_XFER_READY;
    assign stat_err = !reg_rdata[7] && reg_rdata[0];
    assign stat_hit = (reg_rdata == target);

    assign wait_load = (state == ST_RST_SET) || (state == ST_W_CMD);
    assign wait_val  = (state == ST_RST_SET) ? CW'(RST_WAIT_CYC - 1) : CW'(SETTLE_CYC - 1);
    assign poll_load = ((state == ST_RST_WAIT) || (state == ST_SETTLE)) && wait_zero;

    seq_downcount #(.WIDTH(CW)) u_wait (
        .clk(clk), .rst_n(rst_n), .load(wait_load), .load_val(wait_val),
        .dec((state == ST_RST_WAIT) || (state == ST_SETTLE)),
        .cnt(wait_cnt), .zero(wait_zero)
    );

    seq_downcount #(.WIDTH(CW)) u_poll (
        .clk(clk), .rst_n(rst_n), .load(poll_load), .load_val(CW'(POLL_LIMIT - 1)),
        .dec(state == ST_POLL), .cnt(poll_cnt), .zero(poll_zero)
    );

    tf_bus_drive u_bus (
        .state(state), .cmd(cmd_q), .count(count_q), .lba(lba_q), .drive(drive_q),
        .phase(wait_cnt[0]), .addr(reg_addr), .wdata(reg_wdata), .wr(reg_wr), .rd(reg_rd)
    );

    // Next-state selection for the access sequence.
    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE:     if (req_valid) nxt = req_op ? ST_RST_SET : ST_W_CNT;
            ST_RST_SET:  nxt = ST_RST_WAIT;
            ST_RST_WAIT: if (wait_zero) nxt = ST_POLL;
            ST_W_CNT:    nxt = ST_W_LO;
            ST_W_LO:     nxt = ST_W_MID;
            ST_W_MID:    nxt = ST_W_HI;
            ST_W_HI:     nxt = ST_W_DEV;
            ST_W_DEV:    nxt = ST_W_CMD;
            ST_W_CMD:    nxt = ST_SETTLE;
            ST_SETTLE:   if (wait_zero) nxt = ST_POLL;
            ST_POLL: begin
                if (stat_err)                   nxt = ST_RD_ERR;
                else if (stat_hit || poll_zero) nxt = ST_DONE;
            end
            ST_RD_ERR:   nxt = ST_DONE;
            default:     nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Request capture and result recording.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            is_reset_q <= 1'b0;
            drive_q    <= 1'b0;
            cmd_q      <= '0;
            count_q    <= '0;
            lba_q      <= '0;
            err_q      <= '0;
            res_q      <= RES_OK;
        end else if (state == ST_IDLE && req_valid) begin
            is_reset_q <= req_op;
            drive_q    <= req_drive;
            cmd_q      <= req_cmd;
            count_q    <= req_count;
            lba_q      <= req_lba;
            err_q      <= '0;
            res_q      <= RES_OK;
        end else if (state == ST_POLL) begin
            if (stat_err)       res_q <= RES_DEV_ERR;
            else if (stat_hit)  res_q <= RES_OK;
            else if (poll_zero) res_q <= RES_TIMEOUT;
        end else if (state == ST_RD_ERR) begin
            err_q <= reg_rdata;
        end
    end

    assign req_ready = (state == ST_IDLE);
    assign done      = (state == ST_DONE);
    assign result    = res_q;
    assign err_value = err_q;
endmodule

// File: rtl/disk_cmd_seq_chk.sv
`timescale 1ns/1ps
// Protocol checker for disk_cmd_seq, watching only its ports.
// Assumes the parameters are at least 1.
module disk_cmd_seq_chk
    import disk_seq_pkg::*;
#(
    parameter int RST_WAIT_CYC = 400000,
    parameter int SETTLE_CYC   = 80,
    parameter int POLL_LIMIT   = 100000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       req_ready,
    input logic       done,
    input logic [3:0] reg_addr,
    input logic       reg_wr,
    input logic       reg_rd
);
    logic        cmd_wr, ctrl_wr, stat_rd, seen, rst_flag;
    logic [31:0] since, polls;

    assign cmd_wr  = reg_wr && reg_addr == TF_CMD_STAT;
    assign ctrl_wr = reg_wr && reg_addr == TF_CTRL_ALT;
    assign stat_rd = reg_rd && reg_addr == TF_CMD_STAT;

    // Cycles since the last command/control write and the status reads since then.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since <= '0; polls <= '0; seen <= 1'b0; rst_flag <= 1'b0;
        end else if (cmd_wr || ctrl_wr) begin
            since <= 32'd1; polls <= '0; seen <= 1'b1; rst_flag <= ctrl_wr;
        end else begin
            if (since != 32'hFFFF_FFFF) since <= since + 1'b1;
            if (stat_rd) polls <= polls + 1'b1;
        end
    end

    assert_settle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd |-> seen && (rst_flag || since > 32'(SETTLE_CYC)));
    assert_reset_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd |-> (!rst_flag || since > 32'(RST_WAIT_CYC)));
    assert_poll_budget_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd |-> polls < 32'(POLL_LIMIT));
    assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_rd));
    assert_order_lo_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == TF_LBA_LO) |-> $past(reg_wr && reg_addr == TF_COUNT));
    assert_order_dev_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == TF_DEVICE) |-> $past(reg_wr && reg_addr == TF_LBA_HI));
    assert_order_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr |-> $past(reg_wr && reg_addr == TF_DEVICE));
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !req_ready);
endmodule

bind disk_cmd_seq disk_cmd_seq_chk #(
    .RST_WAIT_CYC(RST_WAIT_CYC), .SETTLE_CYC(SETTLE_CYC), .POLL_LIMIT(POLL_LIMIT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .done(done),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd)
);

// File: tb/test_disk_cmd_seq.sv
`timescale 1ns/1ps
module test_disk_cmd_seq;
    localparam int RW = 6, SC = 3, PL = 4;

    logic clk = 0, rst_n = 0;
    logic req_valid = 0, req_op = 0, req_drive = 0;
    logic [7:0] req_cmd = 0, req_count = 0;
    logic [27:0] req_lba = 0;
    logic req_ready, done, reg_wr, reg_rd;
    logic [1:0] result;
    logic [7:0] err_value, reg_wdata, reg_rdata;
    logic [3:0] reg_addr;

    always #2.5 clk = ~clk;

    disk_cmd_seq #(.RST_WAIT_CYC(RW), .SETTLE_CYC(SC), .POLL_LIMIT(PL)) i_disk_cmd_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_cmd(req_cmd), .req_count(req_count), .req_lba(req_lba), .req_drive(req_drive),
        .req_ready(req_ready), .done(done), .result(result), .err_value(err_value),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_rdata(reg_rdata));

    // Drive model
    logic [7:0] m_pre = 0, m_fin = 0, m_err = 0;
    int m_ready_after = 0;
    int stat_reads, cyc, nw, n_settle, t_cmd, t_ctrl, t_stat1, t_done;
    logic [3:0] wa [0:15];
    logic [7:0] wd [0:15];
    logic clr = 0;
    int n_checks = 0, n_fail = 0;

    always_comb begin
        case (reg_addr)
            4'h7:    reg_rdata = (stat_reads < m_ready_after) ? m_pre : m_fin;
            4'h1:    reg_rdata = m_err;
            4'hE:    reg_rdata = 8'hAA;
            default: reg_rdata = 8'h00;
        endcase
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (clr) begin
            nw <= 0; n_settle <= 0; stat_reads <= 0;
            t_cmd <= -1; t_ctrl <= -1; t_stat1 <= -1; t_done <= -1;
        end else begin
            if (reg_wr && nw < 16) begin
                wa[nw] <= reg_addr; wd[nw] <= reg_wdata; nw <= nw + 1;
                if (reg_addr == 4'h7) t_cmd <= cyc;
                if (reg_addr == 4'hE) t_ctrl <= cyc;
            end
            if (reg_rd && reg_addr == 4'h7) begin
                stat_reads <= stat_reads + 1;
                if (t_stat1 < 0) t_stat1 <= cyc;
            end
            if (reg_rd && (reg_addr == 4'h1 || reg_addr == 4'hE) && t_stat1 < 0)
                n_settle <= n_settle + 1;
            if (done) t_done <= cyc;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // Global watchdog
    initial begin
        #(5.0 * 150000);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual 1 expected 0");
        finish_run();
    end

    task automatic run_op(input bit is_rst, input logic [7:0] cmd, input logic [7:0] cnt,
                          input logic [27:0] lba, input bit drv, input int ra,
                          input logic [7:0] pre, input logic [7:0] fin, input logic [7:0] ev);
        logic [7:0] tgt, dev;
        int n, exp_res, guard;
        bit fin_err;
        @(negedge clk);
        m_pre = pre; m_fin = fin; m_err = ev; m_ready_after = ra;
        clr = 1; req_valid = 1; req_op = is_rst; req_cmd = cmd; req_count = cnt;
        req_lba = lba; req_drive = drv;
        @(negedge clk);
        clr = 0; req_valid = 0;
        chk(req_ready == 0, "R9 busy", req_ready, 0);
        guard = 0;
        while (!done && guard < 500) begin @(negedge clk); guard++; end
        chk(guard < 500, "R9 op hung", guard, 0);
        @(negedge clk);
        chk(done == 0, "R9 pulse", done, 0);
        chk(req_ready == 1, "R9 ready", req_ready, 1);
        tgt = is_rst ? 8'h80 : 8'h58;
        fin_err = !fin[7] && fin[0];
        if (ra >= PL)          begin n = PL;     exp_res = 2; end
        else if (fin_err)      begin n = ra + 1; exp_res = 1; end
        else if (fin == tgt)   begin n = ra + 1; exp_res = 0; end
        else                   begin n = PL;     exp_res = 2; end
        if (is_rst) begin
            chk(nw == 1 && wa[0] == 4'hE && wd[0] == 8'h04, "R6 srst write", wd[0], 4);
            chk(t_stat1 - t_ctrl == RW + 1, "R6 reset wait", t_stat1 - t_ctrl, RW + 1);
        end else begin
            dev = 8'hE0 | (8'(drv) << 4) | {4'h0, lba[27:24]};
            chk(nw == 6, "R2 write count", nw, 6);
            chk(wa[0] == 4'h2 && wd[0] == cnt, "R2 count", wd[0], cnt);
            chk(wa[1] == 4'h3 && wd[1] == lba[7:0], "R2 lba lo", wd[1], lba[7:0]);
            chk(wa[2] == 4'h4 && wd[2] == lba[15:8], "R2 lba mid", wd[2], lba[15:8]);
            chk(wa[3] == 4'h5 && wd[3] == lba[23:16], "R2 lba hi", wd[3], lba[23:16]);
            chk(wa[4] == 4'h6 && wd[4] == dev, "R3 device byte", wd[4], dev);
            chk(wa[5] == 4'h7 && wd[5] == cmd, "R2 command", wd[5], cmd);
            chk(t_stat1 - t_cmd == SC + 1, "R4 settle time", t_stat1 - t_cmd, SC + 1);
            chk(n_settle == SC, "R4 discard reads", n_settle, SC);
        end
        chk(stat_reads == n, exp_res == 2 ? "R8 poll count" : "R5 poll count", stat_reads, n);
        chk(int'(result) == exp_res,
            exp_res == 0 ? "R5 result" : (exp_res == 1 ? "R7 result" : "R8 result"),
            result, exp_res);
        chk(err_value == (exp_res == 1 ? ev : 8'h00), "R7 error value", err_value,
            exp_res == 1 ? ev : 0);
        chk(t_done - t_stat1 == n + (exp_res == 1 ? 1 : 0), "R5 done timing",
            t_done - t_stat1, n + (exp_res == 1 ? 1 : 0));
    endtask

    initial begin
        logic [27:0] lbas [0:2];
        logic [7:0] cmds [0:3];
        lbas[0] = 28'h0000000; lbas[1] = 28'hA5C3_7E1; lbas[2] = 28'hFFF_FFFF;
        cmds[0] = 8'h20; cmds[1] = 8'h30; cmds[2] = 8'hC8; cmds[3] = 8'hCA;
        repeat (3) @(negedge clk);
        // R1: state held in reset and just after release
        chk(req_ready == 1 && done == 0 && !reg_wr && !reg_rd, "R1 in reset", done, 0);
        rst_n = 1;
        @(negedge clk);
        chk(req_ready == 1 && done == 0 && !reg_wr && !reg_rd, "R1 after reset", req_ready, 1);
        // Sweep of command patterns, drives and ready delays (R2 R3 R4 R5 R8)
        for (int d = 0; d < 2; d++)
            for (int l = 0; l < 3; l++)
                for (int ra = 0; ra <= PL; ra++)
                    run_op(0, cmds[(l + ra) % 4], 8'(l * 37 + ra + d), lbas[l] ^ 28'(ra << 20),
                           d[0], ra, 8'h80, 8'h58, 8'h00);
        // R7: error with busy clear, at several poll positions
        for (int ra = 0; ra < 3; ra++) run_op(0, 8'h30, 8'h01, 28'h123, 0, ra, 8'h80, 8'h51, 8'h04 + 8'(ra));
        // R7: error bit while busy is ignored
        run_op(0, 8'h20, 8'h02, 28'h456, 1, 2, 8'h81, 8'h58, 8'h10);
        // R8: ready-but-not-transfer value never matches
        run_op(0, 8'hC8, 8'h08, 28'h789, 0, 0, 8'h80, 8'h50, 8'h00);
        // R6: reset sequence with several poll delays
        for (int ra = 0; ra <= PL; ra++) run_op(1, 8'h00, 8'h00, 28'h0, 0, ra, 8'h00, 8'h80, 8'h00);
        // R6 with R7: error during reset polling
        run_op(1, 8'h00, 8'h00, 28'h0, 0, 1, 8'hC0, 8'h41, 8'h02);
        // R10 is held by the checker; confirm idle bus once more
        @(negedge clk);
        chk(!reg_wr && !reg_rd, "R10 idle bus", reg_wr, 0);
        finish_run();
    end
endmodule